// File: doc/BRIEF.md
# Mixed-Decay Fixed Off-Time Chopper Timer

This block sets the timing for the current-regulating chopper of one bridge. It runs on the master oscillator clock. While the bridge is driving, the source-enable output is high. When the current-sense comparator reports that the current has reached its limit, the block drops source-enable and starts a programmable fixed off-time.

The off-time has two parts. It begins in fast decay and switches to slow decay once a separately programmed fast-decay length has passed. If that fast-decay length is longer than the off-time, the whole off-time is fast decay. When the off-time ends, the source is enabled again and a short blanking interval starts. During blanking the comparator is ignored, so that the switching spike cannot end the new on-time at once. A change of the phase bit restarts the blanking interval.

A current code of zero, or an explicit disable request, puts the bridge in an idle state with every output low. Leaving idle enters blanking first.

Top module: `mixdecay_pwm_timer`

## Requirements
- R1: While reset is high, and in the idle state, src_en_o, fast_o and slow_o are all 0. At most one of the three outputs is high in any cycle.
- R2: An off-time with off-time code N (0..31) lasts N*8+7 clock cycles. src_en_o is 0 throughout the off-time.
- R3: An off-time with fast-decay code F (0..15) has fast_o high for its first min(F*8+7, off length) cycles and slow_o high for the remaining cycles. fast_o never follows slow_o within one off-time.
- R4: When F*8+7 is greater than or equal to the off length, slow_o stays 0 for the whole off-time.
- R5: After an off-time, src_en_o is 1 for a blanking interval of 4, 6, 8 or 12 cycles, for blank codes 0, 1, 2 and 3 (binary 00, 01, 10, 11). A trip during blanking is ignored. With trip held high, src_en_o is therefore high for the blank length plus 1 cycle.
- R6: A change of phase_i, seen at a clock edge during blanking, restarts the blanking count from zero.
- R7: level_i equal to 0, or disable_i high, forces all outputs to 0 in the next cycle. When the bridge is enabled again it enters blanking: src_en_o goes high one cycle later.
- R8: A trip that arrives after blanking, while the source is on, ends the on-time. fast_o goes high in the next cycle.
- R9: A trip during the off-time is ignored. Holding trip high does not change the off length.
- R10: With no trip, src_en_o stays high indefinitely after blanking ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Current-sense comparator trip |
| phase_i | input | 1 | Bridge phase bit |
| disable_i | input | 1 | Bridge disable request |
| toff_code_i | input | 5 | Off-time code N |
| tfd_code_i | input | 4 | Fast-decay code F |
| blank_code_i | input | 2 | Blank-time select |
| level_i | input | 6 | Current code; 0 disables the bridge |
| src_en_o | output | 1 | Source driver enable |
| fast_o | output | 1 | Fast decay active |
| slow_o | output | 1 | Slow decay active |

## Verification
The bench holds trip high, so that the block cycles continuously. It then sweeps all 32 off-time codes, each paired with two fast-decay codes and a rotating blank code, and measures the fast, slow and source-on run lengths against arithmetic from the codes. These pairings separate the case where the off-time is split into fast then slow decay from the case where the fast-decay length covers the whole off-time. The continuous trip also exposes any trip that is wrongly accepted during the off-time or during blanking.

Directed sequences cover the remaining behaviour:
- A phase toggle in mid-blank, which must restart the blanking count.
- A zero current code and a disable request, each applied in mid-decay.
- A long run with no trip, where the source must stay on.
- A single trip pulse, which must start the off-time in the next cycle.

// File: rtl/mixdecay_pkg.sv
package mixdecay_pkg;
    parameter int TOFF_W  = 5;
    parameter int TFD_W   = 4;
    parameter int BLANK_W = 2;
    parameter int LVL_W   = 6;
    localparam int CNT_W  = TOFF_W + 3;
    localparam int FD_LW  = TFD_W + 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_DECAY = 2'd2,
        ST_BLANK = 2'd3
    } chop_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] off_len;
        logic [CNT_W-1:0] fd_len;
        logic [CNT_W-1:0] blank_len;
    } len_set_t;

    // (code+1)*8-1 == code*8+7
    function automatic logic [CNT_W-1:0] off_cycles(input logic [TOFF_W-1:0] code);
        return {code, 3'b111};
    endfunction

    function automatic logic [CNT_W-1:0] fd_cycles(input logic [TFD_W-1:0] code);
        logic [FD_LW-1:0] raw;
        raw = {code, 3'b111};
        return CNT_W'(raw);
    endfunction

    function automatic logic [CNT_W-1:0] blank_cycles(input logic [BLANK_W-1:0] code);
        logic [CNT_W-1:0] v;
        case (code)
            2'd0:    v = CNT_W'(4);
            2'd1:    v = CNT_W'(6);
            2'd2:    v = CNT_W'(8);
            default: v = CNT_W'(12);
        endcase
        return v;
    endfunction
endpackage

// File: rtl/mixdecay_len_dec.sv
module mixdecay_len_dec
    import mixdecay_pkg::*;
(
    input  logic [TOFF_W-1:0]  toff_code,
    input  logic [TFD_W-1:0]   tfd_code,
    input  logic [BLANK_W-1:0] blank_code,
    output len_set_t           lens
);
    always_comb begin
        lens.off_len   = off_cycles(toff_code);
        lens.fd_len    = fd_cycles(tfd_code);
        lens.blank_len = blank_cycles(blank_code);
    end
endmodule

// File: rtl/mixdecay_phase_det.sv
module mixdecay_phase_det (
    input  logic clk,
    input  logic rst,
    input  logic phase,
    output logic changed
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= phase;
    end

    assign changed = !rst && (phase != phase_q);
endmodule

// File: rtl/mixdecay_seq.sv
module mixdecay_seq
    import mixdecay_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             trip,
    input  logic             phase_chg,
    input  len_set_t         lens,
    output chop_st_t         st,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (!enable) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st  <= ST_BLANK;
                    cnt <= '0;
                end
                ST_ON: begin
                    if (trip) begin
                        st  <= ST_DECAY;
                        cnt <= '0;
                    end
                end
                ST_DECAY: begin
                    if (cnt == lens.off_len - CNT_W'(1)) begin
                        st  <= ST_BLANK;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (phase_chg) begin
                        cnt <= '0;
                    end else if (cnt == lens.blank_len - CNT_W'(1)) begin
                        st  <= ST_ON;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mixdecay_pwm_timer.sv
module mixdecay_pwm_timer
    import mixdecay_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               trip_i,
    input  logic               phase_i,
    input  logic               disable_i,
    input  logic [TOFF_W-1:0]  toff_code_i,
    input  logic [TFD_W-1:0]   tfd_code_i,
    input  logic [BLANK_W-1:0] blank_code_i,
    input  logic [LVL_W-1:0]   level_i,
    output logic               src_en_o,
    output logic               fast_o,
    output logic               slow_o
);
    len_set_t         lens;
    chop_st_t         st;
    logic [CNT_W-1:0] cnt;
    logic             phase_chg;
    logic             enable;

    assign enable = !disable_i && (level_i != '0);

    mixdecay_len_dec u_len (
        .toff_code  (toff_code_i),
        .tfd_code   (tfd_code_i),
        .blank_code (blank_code_i),
        .lens       (lens)
    );

    mixdecay_phase_det u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase_i),
        .changed (phase_chg)
    );

    mixdecay_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .trip      (trip_i),
        .phase_chg (phase_chg),
        .lens      (lens),
        .st        (st),
        .cnt       (cnt)
    );

    always_comb begin
        src_en_o = (st == ST_ON) || (st == ST_BLANK);
        fast_o   = (st == ST_DECAY) && (cnt < lens.fd_len);
        slow_o   = (st == ST_DECAY) && (cnt >= lens.fd_len);
    end
endmodule

// File: rtl/mixdecay_pwm_timer_chk.sv
module mixdecay_pwm_timer_chk
    import mixdecay_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             trip_i,
    input logic             phase_chg,
    input logic             enable,
    input chop_st_t         st,
    input logic [CNT_W-1:0] cnt,
    input logic             src_en_o,
    input logic             fast_o,
    input logic             slow_o
);
    // R1
    one_output_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({src_en_o, fast_o, slow_o}) <= 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!src_en_o && !fast_o && !slow_o));

    // R7
    disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!src_en_o && !fast_o && !slow_o));

    // R8
    trip_start_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && st == ST_ON && trip_i) |=> fast_o);

    // R3
    no_fast_after_slow_chk: assert property (@(posedge clk) disable iff (rst)
        slow_o |=> !fast_o);

    // R6
    blank_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && st == ST_BLANK && phase_chg) |=> (st == ST_BLANK && cnt == '0));

    // R5
    blank_masks_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && st == ST_BLANK && trip_i) |=> src_en_o);
endmodule

bind mixdecay_pwm_timer mixdecay_pwm_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trip_i    (trip_i),
    .phase_chg (phase_chg),
    .enable    (enable),
    .st        (st),
    .cnt       (cnt),
    .src_en_o  (src_en_o),
    .fast_o    (fast_o),
    .slow_o    (slow_o)
);

// File: tb/mixdecay_pwm_timer_tb.sv
`timescale 1ns/1ps
module mixdecay_pwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trip_i = 1'b0;
    logic       phase_i = 1'b0;
    logic       disable_i = 1'b0;
    logic [4:0] toff_code_i = '0;
    logic [3:0] tfd_code_i = '0;
    logic [1:0] blank_code_i = '0;
    logic [5:0] level_i = 6'd20;
    logic       src_en_o, fast_o, slow_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mixdecay_pwm_timer u_dut (
        .clk(clk), .rst(rst), .trip_i(trip_i), .phase_i(phase_i),
        .disable_i(disable_i), .toff_code_i(toff_code_i), .tfd_code_i(tfd_code_i),
        .blank_code_i(blank_code_i), .level_i(level_i),
        .src_en_o(src_en_o), .fast_o(fast_o), .slow_o(slow_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blank_len(input int code);
        case (code)
            0: return 4;
            1: return 6;
            2: return 8;
            default: return 12;
        endcase
    endfunction

    // Waits for the start of an off-time, then counts one full period.
    task automatic measure(output int nf, output int ns, output int nb, output int bad);
        int guard;
        nf = 0; ns = 0; nb = 0; bad = 0; guard = 0;
        @(negedge clk);
        while (!src_en_o && guard < 2000) begin guard++; @(negedge clk); end
        while (src_en_o && guard < 4000) begin guard++; @(negedge clk); end
        while (!src_en_o && guard < 6000) begin
            if (fast_o) begin
                nf++;
                if (ns > 0) bad = 1;
            end else if (slow_o) ns++;
            else bad = 1;
            guard++;
            @(negedge clk);
        end
        while (src_en_o && guard < 8000) begin
            nb++; guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int nf, ns, nb, bad, off, fd, ef, n_hi;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset src_en", src_en_o, 0);
        check("R1 reset fast", fast_o, 0);
        check("R1 reset slow", slow_o, 0);
        rst = 1'b0;
        trip_i = 1'b1;

        // R2 R3 R4 R5 R9: sweep with trip held high
        for (int n = 0; n < 32; n++) begin
            for (int k = 0; k < 2; k++) begin
                int f;
                f = (k == 0) ? (n % 16) : ((n * 7 + 3) % 16);
                toff_code_i  = 5'(n);
                tfd_code_i   = 4'(f);
                blank_code_i = 2'((n + k) % 4);
                measure(nf, ns, nb, bad);
                measure(nf, ns, nb, bad);
                off = n * 8 + 7;
                fd  = f * 8 + 7;
                ef  = (fd < off) ? fd : off;
                check("R2 R9 off length", nf + ns, off);
                check("R3 fast length", nf, ef);
                check("R3 order", bad, 0);
                if (fd >= off) check("R4 no slow", ns, 0);
                check("R5 blank plus on", nb, blank_len((n + k) % 4) + 1);
            end
        end

        // R6: phase toggle mid-blank restarts blanking
        toff_code_i = 5'd0; tfd_code_i = 4'd0; blank_code_i = 2'd3;
        measure(nf, ns, nb, bad);
        @(negedge clk);
        while (src_en_o) @(negedge clk);
        while (!src_en_o) @(negedge clk);
        n_hi = 0;
        while (src_en_o && n_hi < 100) begin
            n_hi++;
            if (n_hi == 5) phase_i = ~phase_i;
            @(negedge clk);
        end
        check("R6 blank restart", n_hi, 5 + 12 + 1);

        // R7: zero level mid-decay
        blank_code_i = 2'd1;
        toff_code_i = 5'd4;
        while (!fast_o) @(negedge clk);
        level_i = 6'd0;
        @(negedge clk);
        check("R7 level zero src", src_en_o, 0);
        check("R7 level zero decay", fast_o | slow_o, 0);
        repeat (20) @(negedge clk);
        check("R7 stays idle", src_en_o | fast_o | slow_o, 0);
        level_i = 6'd9;
        @(negedge clk);
        n_hi = 0;
        while (src_en_o && n_hi < 100) begin n_hi++; @(negedge clk); end
        check("R7 reenable blank", n_hi, 6 + 1);
        check("R8 decay after reenable", fast_o, 1);

        // R7: disable request mid-decay
        while (!fast_o) @(negedge clk);
        disable_i = 1'b1;
        @(negedge clk);
        check("R7 disable", src_en_o | fast_o | slow_o, 0);
        disable_i = 1'b0;
        @(negedge clk);
        check("R7 disable release", src_en_o, 1);

        // R10: no trip keeps source on
        trip_i = 1'b0;
        repeat (300) @(negedge clk);
        check("R10 source held", src_en_o, 1);
        check("R10 no decay", fast_o | slow_o, 0);

        // R8: single trip pulse
        trip_i = 1'b1;
        @(negedge clk);
        trip_i = 1'b0;
        check("R8 trip fast", fast_o, 1);
        check("R8 trip src off", src_en_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule